// File: doc/BRIEF.md
# Clock and Reset Control Register File

This block is the software-visible control surface of a chip's clock generator. It holds the clock-gate, source-select, divider, peripheral-reset and watchdog-reset-control words, and four PLL control words whose lock flags the block itself maintains. It also offers two free-running timebase words: a counter of 25 MHz cycles and a count of whole seconds since the last cold reset. Software reaches it over a simple 32-bit register bus with a 4 KiB byte-address window. Reads return their data one cycle after the request.

The PLL analog loop is not modelled. A PLL counts as locked at once unless its power-down bit is set. A tick input, pulsed once every 640 ns by the surrounding clock logic, drives the cycle counter. The counter adds 16 on each tick, so that it tracks a 25 MHz count at a coarser step. It returns to zero once it has stepped through a full second, and each return advances the seconds word.

Word map (byte offsets): 0x00 gate A, 0x04 source select, 0x08 divider A, 0x0C PLL0, 0x10 PLL1, 0x14 software-reset trigger, 0x18 gate B, 0x1C gate C, 0x20 divider B, 0x24 peripheral reset A, 0x28 peripheral reset B, 0x2C PLL2, 0x30 PLL3, 0x34 bus clock frequency, 0x38 watchdog reset control, 0x3C seconds, 0x40 cycle counter.

Top module: `clkctl_regs`

## Requirements
- R1: On cold reset (rst high at a clock edge) the words take these values: gates A, B and C 0xFFFFFFFF, source select 0x004AAAAA, divider A 0x5413F855, divider B 0xAA4F8F9F, PLL0 0x80222101, PLL1 0x80202101, PLL2 0x80C02105, PLL3 0x81228606, peripheral reset A 0x00001000, peripheral reset B 0x80000000, bus clock frequency 0x000000C8, watchdog reset control 0xFFFFFFFF, seconds 0, cycle counter 0.
- R2: A plain control word returns on read the full 32-bit value last written to it.
- R3: A write to a PLL word with bit 12 (power-down) set stores the written bits 29:0, clears bit 31 (locked) and sets bit 30 (loss-of-lock).
- R4: A write to a PLL word with bit 12 clear stores the written bits 29:0 and sets bit 31. Bit 30 keeps its old value unless the write carries a 1 there, which clears it. The word does not change without a write.
- R5: The software-reset trigger at 0x14 always reads zero, whatever is written to it.
- R6: The seconds and cycle-counter words are read-only, and writes to them leave their values unchanged.
- R7: The cycle counter changes only on a tick, adds 16 per tick, keeps bits 3:0 at zero, and returns to zero after reaching 16*(TICKS_PER_SEC-1).
- R8: The seconds word increments by one each time the cycle counter returns to zero, and at no other time.
- R9: A word offset past the last word (0x44 and above) reads zero, and a write there changes no word, including any word that shares its low address bits.
- R10: An access whose byte address has bits 1:0 non-zero is ignored: a write changes nothing and a read returns zero.
- R11: For a read request accepted at a clock edge, bus_rvalid is high and bus_rdata holds the word after that same edge. bus_rvalid is low after an edge with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| tick | input | 1 | One-cycle enable, once every 640 ns |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The assertions take it for granted that tick is a single-cycle pulse and that rst is held for at least one edge before any bus traffic. They also assume that bus_wr and bus_addr are meaningful only while bus_sel is high. The bench drives every input half a cycle away from the active edge. It holds tick low during all register-access vectors, so the live words stay fixed there. It then issues tick bursts of known length with a small TICKS_PER_SEC, so that counter wraps and seconds increments fall inside a short run.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 17;

  // word indices
  localparam int W_GATE_A  = 0;
  localparam int W_SRC_SEL = 1;
  localparam int W_DIV_A   = 2;
  localparam int W_PLL0    = 3;
  localparam int W_PLL1    = 4;
  localparam int W_SWRST   = 5;
  localparam int W_GATE_B  = 6;
  localparam int W_GATE_C  = 7;
  localparam int W_DIV_B   = 8;
  localparam int W_IPRST_A = 9;
  localparam int W_IPRST_B = 10;
  localparam int W_PLL2    = 11;
  localparam int W_PLL3    = 12;
  localparam int W_BUSFREQ = 13;
  localparam int W_WDRST   = 14;
  localparam int W_SECS    = 15;
  localparam int W_CYC     = 16;

  // PLL control bit positions
  localparam int PLL_LOCK_BIT = 31;
  localparam int PLL_LOSS_BIT = 30;
  localparam int PLL_PD_BIT   = 12;

  typedef enum logic [1:0] {
    KIND_STORE = 2'd0,
    KIND_PLL   = 2'd1,
    KIND_ZERO  = 2'd2,
    KIND_LIVE  = 2'd3
  } word_kind_e;

  function automatic word_kind_e kind_of(input int idx);
    case (idx)
      W_PLL0, W_PLL1, W_PLL2, W_PLL3: return KIND_PLL;
      W_SWRST:                        return KIND_ZERO;
      W_SECS, W_CYC:                  return KIND_LIVE;
      default:                        return KIND_STORE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] cold_value(input int idx);
    case (idx)
      W_GATE_A, W_GATE_B, W_GATE_C, W_WDRST: return 32'hFFFF_FFFF;
      W_SRC_SEL: return 32'h004A_AAAA;
      W_DIV_A:   return 32'h5413_F855;
      W_DIV_B:   return 32'hAA4F_8F9F;
      W_PLL0:    return 32'h8022_2101;
      W_PLL1:    return 32'h8020_2101;
      W_PLL2:    return 32'h80C0_2105;
      W_PLL3:    return 32'h8122_8606;
      W_IPRST_A: return 32'h0000_1000;
      W_IPRST_B: return 32'h8000_0000;
      W_BUSFREQ: return 32'h0000_00C8;
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/clkctl_store_word.sv
module clkctl_store_word #(
  parameter int                  W       = 32,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (we)  q <= wdata;
  end

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q)); // R2

endmodule

// File: rtl/clkctl_pll_word.sv
module clkctl_pll_word
  import clkctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = wdata;
    if (wdata[PLL_PD_BIT]) begin
      nxt[PLL_LOCK_BIT] = 1'b0;
      nxt[PLL_LOSS_BIT] = 1'b1;
    end else begin
      nxt[PLL_LOCK_BIT] = 1'b1;
      nxt[PLL_LOSS_BIT] = q[PLL_LOSS_BIT] & ~wdata[PLL_LOSS_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= nxt;
  end

  AST_PD_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[PLL_PD_BIT]) |=> (!q[PLL_LOCK_BIT] && q[PLL_LOSS_BIT])); // R3

  AST_RUN_SETS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (we && !wdata[PLL_PD_BIT]) |=> q[PLL_LOCK_BIT]); // R4

  AST_LOSS_W1C: assert property (@(posedge clk) disable iff (rst)
    (we && !wdata[PLL_PD_BIT] && wdata[PLL_LOSS_BIT]) |=> !q[PLL_LOSS_BIT]); // R4

  AST_PLL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q)); // R4

endmodule

// File: rtl/clkctl_timebase.sv
module clkctl_timebase #(
  parameter int W             = 32,
  parameter int STEP          = 16,
  parameter int TICKS_PER_SEC = 1562500
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cyc_q,
  output logic [W-1:0] sec_q
);

  localparam logic [W-1:0] CYC_WRAP = W'(STEP * TICKS_PER_SEC);
  localparam logic [W-1:0] CYC_LAST = W'(STEP * (TICKS_PER_SEC - 1));
  localparam logic [W-1:0] STEP_V   = W'(STEP);

  logic at_last;
  assign at_last = (cyc_q == CYC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      sec_q <= '0;
    end else if (tick) begin
      if (at_last) begin
        cyc_q <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + STEP_V;
      end
    end
  end

  AST_CYC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cyc_q < CYC_WRAP); // R7

  AST_CYC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cyc_q)); // R7

  AST_SEC_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sec_q != $past(sec_q)) |-> ($past(tick) && cyc_q == '0)); // R8

endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int TICK_STEP     = 16,
  parameter int TICKS_PER_SEC = 1562500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);

  localparam int WORD_AW = ADDR_W - 2;
  localparam int SEL_W   = $clog2(NUM_WORDS);

  logic [WORD_AW-1:0] word_idx;
  logic [SEL_W-1:0]   sel_idx;
  logic               aligned;
  logic               in_range;
  logic               wr_ok;
  logic               rd_ok;
  logic [DATA_W-1:0]  word_q [NUM_WORDS];
  logic [DATA_W-1:0]  cyc_val;
  logic [DATA_W-1:0]  sec_val;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign sel_idx  = word_idx[SEL_W-1:0];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_range = (word_idx < WORD_AW'(NUM_WORDS));
  assign wr_ok    = bus_sel && bus_wr && aligned && in_range;
  assign rd_ok    = bus_sel && !bus_wr;

  clkctl_timebase #(
    .W             (DATA_W),
    .STEP          (TICK_STEP),
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) u_timebase (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .cyc_q (cyc_val),
    .sec_q (sec_val)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam word_kind_e KIND = kind_of(i);
    logic we_i;
    assign we_i = wr_ok && (word_idx == WORD_AW'(i));

    if (KIND == KIND_PLL) begin : g_pll
      clkctl_pll_word #(.RST_VAL(cold_value(i))) u_pll (
        .clk   (clk),
        .rst   (rst),
        .we    (we_i),
        .wdata (bus_wdata),
        .q     (word_q[i])
      );
    end else if (KIND == KIND_STORE) begin : g_store
      clkctl_store_word #(.W(DATA_W), .RST_VAL(cold_value(i))) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (we_i),
        .wdata (bus_wdata),
        .q     (word_q[i])
      );
    end else if (KIND == KIND_ZERO) begin : g_zero
      assign word_q[i] = '0;
    end else begin : g_live
      assign word_q[i] = (i == W_SECS) ? sec_val : cyc_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_ok;
      if (rd_ok)
        bus_rdata <= (aligned && in_range) ? word_q[sel_idx] : '0;
    end
  end

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !in_range) |=> (bus_rdata == '0)); // R9

  AST_MISALIGN_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !aligned) |=> (bus_rdata == '0)); // R10

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid); // R11

  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !bus_rvalid); // R11

  AST_SWRST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && aligned && word_idx == WORD_AW'(W_SWRST)) |=> (bus_rdata == '0)); // R5

endmodule

// File: tb/clkctl_regs_test.sv
module clkctl_regs_test;

  localparam int TPS  = 8;
  localparam int STEP = 16;
  localparam int NV   = 34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkctl_regs #(.ADDR_W(12), .TICK_STEP(STEP), .TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  // {write, byte address, data (write data, or expected read value), req}
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'hFFFF_FFFF, 4'd1},  // R1 gate A
    {1'b0, 12'h004, 32'h004A_AAAA, 4'd1},  // R1 select
    {1'b0, 12'h008, 32'h5413_F855, 4'd1},  // R1 divider A
    {1'b0, 12'h00C, 32'h8022_2101, 4'd1},  // R1 PLL0
    {1'b0, 12'h034, 32'h0000_00C8, 4'd1},  // R1 bus freq
    {1'b0, 12'h02C, 32'h80C0_2105, 4'd1},  // R1 PLL2
    {1'b0, 12'h030, 32'h8122_8606, 4'd1},  // R1 PLL3
    {1'b0, 12'h024, 32'h0000_1000, 4'd1},  // R1 peripheral reset A
    {1'b0, 12'h014, 32'h0000_0000, 4'd5},  // R5
    {1'b0, 12'h040, 32'h0000_0000, 4'd1},  // R1 cycle counter
    {1'b1, 12'h008, 32'h1234_5678, 4'd2},
    {1'b0, 12'h008, 32'h1234_5678, 4'd2},  // R2
    {1'b1, 12'h018, 32'h0F0F_0F0F, 4'd2},
    {1'b0, 12'h018, 32'h0F0F_0F0F, 4'd2},  // R2
    {1'b1, 12'h014, 32'hFFFF_FFFF, 4'd5},
    {1'b0, 12'h014, 32'h0000_0000, 4'd5},  // R5
    {1'b1, 12'h040, 32'h0000_ABC0, 4'd6},
    {1'b0, 12'h040, 32'h0000_0000, 4'd6},  // R6
    {1'b1, 12'h03C, 32'h0000_0055, 4'd6},
    {1'b0, 12'h03C, 32'h0000_0000, 4'd6},  // R6
    {1'b1, 12'h00C, 32'h0000_1000, 4'd3},
    {1'b0, 12'h00C, 32'h4000_1000, 4'd3},  // R3
    {1'b1, 12'h00C, 32'h0000_0101, 4'd4},
    {1'b0, 12'h00C, 32'hC000_0101, 4'd4},  // R4 loss stays
    {1'b1, 12'h00C, 32'h4000_0101, 4'd4},
    {1'b0, 12'h00C, 32'h8000_0101, 4'd4},  // R4 loss cleared
    {1'b1, 12'h010, 32'hC000_2222, 4'd4},
    {1'b0, 12'h010, 32'h8000_2222, 4'd4},  // R4
    {1'b1, 12'h0A0, 32'h0000_DEAD, 4'd9},
    {1'b0, 12'h0A0, 32'h0000_0000, 4'd9},  // R9
    {1'b1, 12'h800, 32'h0000_0000, 4'd9},
    {1'b0, 12'h000, 32'hFFFF_FFFF, 4'd9},  // R9 no alias
    {1'b1, 12'h009, 32'h0000_0000, 4'd10},
    {1'b0, 12'h008, 32'h1234_5678, 4'd10}  // R10
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    check(11, {31'd0, bus_rvalid}, 32'd1); // R11 valid after read
  endtask

  task automatic pulse_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) bus_write(VEC[i][47:36], VEC[i][35:4]);
      else begin
        bus_read(VEC[i][47:36], rd);
        check(int'(VEC[i][3:0]), rd, VEC[i][35:4]);
      end
    end

    // R10 misaligned read returns zero
    bus_read(12'h009, rd);
    check(10, rd, 32'h0);
    // R11 no valid on idle cycle
    @(negedge clk);
    check(11, {31'd0, bus_rvalid}, 32'd0);

    // R1 cold reset restores written words
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus_read(12'h008, rd); check(1, rd, 32'h5413_F855);
    bus_read(12'h00C, rd); check(1, rd, 32'h8022_2101);
    bus_read(12'h020, rd); check(1, rd, 32'hAA4F_8F9F);

    // R7 counter step
    pulse_ticks(3);
    bus_read(12'h040, rd); check(7, rd, 32'd48);
    bus_read(12'h03C, rd); check(8, rd, 32'd0);
    // R7 wrap, R8 seconds advance
    pulse_ticks(5);
    bus_read(12'h040, rd); check(7, rd, 32'd0);
    bus_read(12'h03C, rd); check(8, rd, 32'd1);
    pulse_ticks(19);
    bus_read(12'h040, rd); check(7, rd, 32'd48);
    bus_read(12'h03C, rd); check(8, rd, 32'd3);
    // R6 write to live words while running is discarded
    bus_write(12'h040, 32'h0000_0010);
    bus_read(12'h040, rd); check(6, rd, 32'd48);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule